// File: doc/BRIEF.md
# I2C Target Register Access Controller

This block is an I2C target that lets a host processor read and write a bank of 8-bit configuration registers. SCL and SDA are oversampled by a system clock. The block finds start, repeated-start and stop conditions, answers a fixed 7-bit address, and drives SDA low through an output enable. It never drives SDA high. The register bank sits outside the block and connects through a plain register-file port: address, write data, a one-cycle write strobe, and combinational read data.

A write transaction carries a one-byte register offset and then any number of data bytes. The data bytes go to consecutive registers. Reads start from a read pointer that is kept between transactions. This pointer starts at 00h after reset. Each offset byte loads it, and it steps forward after every byte sent to the host, whether the host acknowledges that byte or not. A read with no offset phase therefore carries on from where the last read stopped, or from the offset of the most recent write. A repeated start with the read bit set gives a random-access read.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges (drives SDA low in the ninth bit slot) only the address bytes 0x7C (write) and 0x7D (read), i.e. target address 0x3E. After any other address byte it does not acknowledge, never drives SDA, and issues no write until the next start or stop.
- R2: In a write transaction, the first byte after the address is the register offset, sent MSB first. Each later byte is written to offset, offset+1, …. Each write is a single `reg_we` pulse of one clock carrying the address and data. The block acknowledges every offset and data byte.
- R3: A write transaction that holds only an offset byte and then a stop produces no `reg_we` pulse. A later read without an offset starts at that offset.
- R4: After reset, a read without an offset phase returns register 00h first, then 01h, 02h, and so on.
- R5: The read pointer advances by one after every byte sent to the host. A later read without an offset continues at the register after the last one sent.
- R6: A write with data bytes sets the next read start to its offset, not to the register after the last byte written.
- R7: An offset write followed by a repeated start and address 0x7D returns data from that offset, MSB first.
- R8: An ACK (SDA low) from the host after a read byte makes the block send the next register. A NACK (SDA high) makes the block release SDA and send nothing more until a start or stop, even while SCL keeps toggling.
- R9: The read and write pointers are 8 bits wide and wrap from FFh to 00h.
- R10: `sda_oe` changes only while SCL is low. It is 0 after reset and during every bit that the host drives.
- R11: A start, repeated start or stop in the middle of a byte drops that byte and writes nothing. A stop leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | High pulls SDA low; low releases it |
| reg_addr | output | 8 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register-file read data for `reg_addr` |

## Verification
Each pad edge passes through two synchroniser flops and one edge-detect flop, so the block reacts three clocks after the edge. `sda_oe` moves three clocks after a falling SCL. The write strobe fires three clocks after the falling SCL that ends the eighth data bit. The bench holds each quarter of an SCL period for eight clocks and drives and samples only on falling clock edges, so every response has settled at least five clocks before it is read. A reference model in the bench tracks the read pointer and the register contents, and on every clock it compares each write strobe against a queue of expected writes and checks SDA drive against SCL.

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
module i2c_reg_target #(
  parameter logic [6:0] TARGET_ADDR = 7'h3E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam logic [3:0] S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2, S_OFFS = 4'd3,
                         S_OACK = 4'd4, S_WDAT = 4'd5, S_WACK = 4'd6, S_RDAT = 4'd7,
                         S_RACK = 4'd8, S_IGN  = 4'd9;

  logic [2:0] scl_p, sda_p;
  logic [3:0] state, cnt;
  logic [7:0] sh, tx, rptr, wptr;
  logic       rw, oe, we, host_nack;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       start_det, stop_det, rise, fall;

  assign scl_s = scl_p[1];
  assign scl_q = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_q = sda_p[2];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise = scl_s & ~scl_q;
  assign fall = ~scl_s & scl_q;

  assign sda_oe    = oe;
  assign reg_we    = we;
  assign reg_wdata = sh;
  assign reg_addr  = rw ? rptr : wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rptr      <= '0;
      wptr      <= '0;
      rw        <= 1'b0;
      oe        <= 1'b0;
      we        <= 1'b0;
      host_nack <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        state <= S_ADDR;
        cnt   <= '0;
        oe    <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE;
        oe    <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_OFFS, S_WDAT: begin
            if (rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == S_ADDR) begin
                if (sh[7:1] == TARGET_ADDR) begin
                  rw    <= sh[0];
                  oe    <= 1'b1;
                  state <= S_AACK;
                end else begin
                  state <= S_IGN;
                end
              end else if (state == S_OFFS) begin
                rptr  <= sh;
                wptr  <= sh;
                oe    <= 1'b1;
                state <= S_OACK;
              end else begin
                we    <= 1'b1;
                oe    <= 1'b1;
                state <= S_WACK;
              end
            end
          end
          S_AACK: if (fall) begin
            cnt <= '0;
            if (rw) begin
              tx    <= reg_rdata;
              oe    <= ~reg_rdata[7];
              state <= S_RDAT;
            end else begin
              oe    <= 1'b0;
              state <= S_OFFS;
            end
          end
          S_OACK: if (fall) begin
            oe    <= 1'b0;
            state <= S_WDAT;
          end
          S_WACK: if (fall) begin
            oe    <= 1'b0;
            wptr  <= wptr + 8'd1;
            state <= S_WDAT;
          end
          S_RDAT: if (fall) begin
            if (cnt == 4'd7) begin
              oe    <= 1'b0;
              rptr  <= rptr + 8'd1;
              state <= S_RACK;
            end else begin
              cnt <= cnt + 4'd1;
              tx  <= {tx[6:0], 1'b0};
              oe  <= ~tx[6];
            end
          end
          S_RACK: begin
            if (rise) host_nack <= sda_s;
            else if (fall) begin
              cnt <= '0;
              if (!host_nack) begin
                tx    <= reg_rdata;
                oe    <= ~reg_rdata[7];
                state <= S_RDAT;
              end else begin
                state <= S_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_reg_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [3:0] state,
  input logic [7:0] rptr,
  input logic       stop_det
);
  // R2
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);
  // R1
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd9) |-> (!sda_oe && !reg_we));
  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !reg_we));
  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rptr) == 8'hFF && rptr != 8'hFF) |-> (rptr == 8'h00));
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .reg_we(reg_we),
  .state(state), .rptr(rptr), .stop_det(stop_det)
);

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] mmem [256];
  int mrptr = 0;
  int checks = 0, fails = 0;
  logic [15:0] wq[$];
  bit quiet = 0;
  int quiet_viol = 0, oe_bad = 0;
  logic prev_oe = 1'b0;

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  i2c_reg_target u_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        if (wq.size() == 0) chk("R2 unexpected write", {reg_addr, reg_wdata}, 0);
        else chk("R2 write", {reg_addr, reg_wdata}, wq.pop_front());
      end
      if (sda_oe != prev_oe && scl_m) oe_bad++;
      if (quiet && sda_oe) quiet_viol++;
    end
    prev_oe <= sda_oe;
  end

  task automatic wq_n(input int n); repeat (n) @(negedge clk); endtask
  task automatic i2c_start; sda_m = 1; scl_m = 1; wq_n(Q); sda_m = 0; wq_n(Q); scl_m = 0; wq_n(Q); endtask
  task automatic i2c_rstart; sda_m = 1; wq_n(Q); scl_m = 1; wq_n(Q); sda_m = 0; wq_n(Q); scl_m = 0; wq_n(Q); endtask
  task automatic i2c_stop; sda_m = 0; wq_n(Q); scl_m = 1; wq_n(Q); sda_m = 1; wq_n(Q); endtask
  task automatic wbit(input logic b); sda_m = b; wq_n(Q); scl_m = 1; wq_n(2*Q); scl_m = 0; wq_n(Q); endtask
  task automatic rbit(output logic b); sda_m = 1; wq_n(Q); scl_m = 1; wq_n(Q); b = sda_line; wq_n(Q); scl_m = 0; wq_n(Q); endtask

  task automatic wbyte(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack_n);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(!ack);
  endtask

  task automatic read_n(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rbyte(d, i != n - 1);
      chk(req, d, mmem[mrptr]);
      mrptr = (mrptr + 1) % 256;
    end
  endtask

  task automatic plain_read(input int n, input string req);
    logic a;
    i2c_start; wbyte(8'h7D, a); chk("R1 read address ack", a, 0);
    read_n(n, req);
    i2c_stop;
  endtask

  task automatic set_offset(input logic [7:0] off);
    logic a;
    wbyte(8'h7C, a); chk("R1 write address ack", a, 0);
    wbyte(off, a); chk("R2 offset ack", a, 0);
    mrptr = off;
  endtask

  task automatic put(input logic [7:0] addr, input logic [7:0] d);
    logic a;
    wq.push_back({addr, d});
    mmem[addr] = d;
    wbyte(d, a); chk("R2 data ack", a, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i * 37 + 11);
      mmem[i] = 8'(i * 37 + 11);
    end
    wq_n(5);
    rst_n = 1'b1;
    wq_n(4);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R2 reset reg_we", reg_we, 0);

    plain_read(3, "R4 read from 00h after reset");
    plain_read(2, "R5 read continues at last+1");

    i2c_start; set_offset(8'h10);
    put(8'h10, 8'hA1); put(8'h11, 8'hB2); put(8'h12, 8'hC3);
    i2c_stop;
    mrptr = 8'h10;
    plain_read(3, "R6 read starts at write offset");

    i2c_start; set_offset(8'h40); i2c_stop;
    plain_read(1, "R3 offset-only write sets read start");

    i2c_start; set_offset(8'h20); i2c_rstart;
    wbyte(8'h7D, a); chk("R7 repeated start address ack", a, 0);
    read_n(2, "R7 random read from offset");
    i2c_stop;

    i2c_start; quiet = 1;
    wbyte(8'h7E, a); chk("R1 foreign address nack", a, 1);
    wbyte(8'h05, a); chk("R1 ignored byte nack", a, 1);
    wbyte(8'h99, a); chk("R1 ignored byte nack", a, 1);
    i2c_stop; quiet = 0;
    chk("R1 no drive after foreign address", quiet_viol, 0);
    chk("R1 register 05h untouched", mem[8'h05], mmem[8'h05]);

    i2c_start; set_offset(8'hFE);
    put(8'hFE, 8'h5A); put(8'hFF, 8'h6B); put(8'h00, 8'h7C);
    i2c_rstart;
    wbyte(8'h7D, a); chk("R9 address ack", a, 0);
    read_n(3, "R9 read wraps FFh to 00h");
    i2c_stop;

    i2c_start; wbyte(8'h7D, a); chk("R8 address ack", a, 0);
    rbyte(d, 1'b1); chk("R8 byte before ack", d, mmem[mrptr]); mrptr = (mrptr + 1) % 256;
    rbyte(d, 1'b0); chk("R8 byte before nack", d, mmem[mrptr]); mrptr = (mrptr + 1) % 256;
    quiet = 1;
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    chk("R8 silent after nack", d, 8'hFF);
    wbit(1'b1);
    i2c_stop; quiet = 0;
    chk("R8 no drive after nack", quiet_viol, 0);
    plain_read(1, "R5 pointer advanced past nacked byte");

    i2c_start; set_offset(8'h30);
    wbit(1); wbit(0); wbit(1); wbit(0);
    i2c_rstart;
    wbyte(8'h7D, a); chk("R11 address ack after abort", a, 0);
    read_n(1, "R11 aborted byte not written");
    i2c_stop;
    chk("R11 sda released after stop", sda_oe, 0);

    chk("R2 all expected writes seen", wq.size(), 0);
    chk("R10 sda_oe changed only with SCL low", oe_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule